// File: doc/BRIEF.md
# Single-Source Interrupt Status/Mask Unit

This unit sits between one downstream device and an upstream interrupt controller. The device raises a level-sensitive request. The unit captures that request in a sticky status flag at bit 14 of a status word. A mask flag, held at bit 14 of a second word, decides whether the captured request goes upstream. The upstream line is a registered copy of the pending condition, which is status AND mask.

Software reaches both words through a small register bus. The status word is at offset 0x4C and the mask word is at offset 0x50. Software starts by clearing both words. It unmasks the source with a read-modify-write of the mask word. To mask and acknowledge, it first clears the mask bit and then writes a 1 to status bit 14, which clears the status bit (write-one-to-clear).

When the upstream side services the line, it pulses a service input. If nothing is pending at that moment, the unit reports a spurious interrupt with a one-cycle pulse.

Top module: `irq_stat_unit`

## Requirements
- R1: After reset, status bit 14, mask bit 14, `irq_out` and `spurious` are all 0.
- R2: While `dev_irq` is sampled high at a clock edge, status bit 14 (offset 0x4C) reads 1 after that edge. It stays 1 after `dev_irq` drops, until software clears it.
- R3: A write to offset 0x4C with data bit 14 = 1 clears status bit 14 at that edge. A write with data bit 14 = 0 leaves the bit unchanged.
- R4: If `dev_irq` is still high during a clearing write, status bit 14 reads 0 after the write edge and reads 1 again after the following edge.
- R5: A write to offset 0x50 loads mask bit 14 from data bit 14. The bit reads back at bit 14 of offset 0x50.
- R6: `irq_out` equals (status bit 14 AND mask bit 14) as it was one clock earlier.
- R7: A `svc_req` sampled high while nothing is pending gives `spurious` = 1 for exactly the following cycle. When the source is pending, `svc_req` gives no pulse.
- R8: Every bit other than bit 14, and every offset other than 0x4C and 0x50, reads 0. Writes to those bits and offsets change nothing.
- R9: Software can mask the source by clearing the mask bit and then acknowledge it with a status write of bit 14 = 1, once the source has gone low. After this sequence, status reads 0, mask reads 0, and `irq_out` is 0 one edge after the mask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| dev_irq | input | 1 | Level-sensitive device request |
| svc_req | input | 1 | Upstream service pulse |
| irq_out | output | 1 | Registered request to the upstream controller |
| spurious | output | 1 | One-cycle spurious-service indication |

## Verification
The hardest case to reach is a clearing write that lands while the device is still asserting its request. Here the clear and the re-capture compete, and the outcome is visible only across two consecutive edges. The bench holds `dev_irq` high, issues the write-one-to-clear, and reads status once right after the write edge (expecting 0) and once after the next edge (expecting 1). Spurious detection also needs an unmasked but clear status at the moment of service. The bench reaches that state by enabling the mask and clearing status with the source low, before pulsing `svc_req`.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_stat_dec.sv
module irq_stat_dec
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h4C,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h50
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == STAT_OFS)      return SEL_STAT;
    else if (a == MASK_OFS) return SEL_MASK;
    else                    return SEL_NONE;
  endfunction

  assign sel = decode(addr);
endmodule

// File: rtl/irq_stat_regs.sv
module irq_stat_regs
  import irq_stat_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SRC_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          sel,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dev_irq,
  output logic              stat_bit,
  output logic              mask_bit,
  output logic              stat_clr,
  output logic              mask_wr,
  output logic [DATA_W-1:0] rdata
);
  function automatic logic [DATA_W-1:0] place_bit(input logic b);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SRC_BIT] = b;
    return w;
  endfunction

  assign stat_clr = wr && (sel == SEL_STAT) && wdata[SRC_BIT];
  assign mask_wr  = wr && (sel == SEL_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_bit <= 1'b0;
      mask_bit <= 1'b0;
    end else begin
      stat_bit <= stat_clr ? 1'b0 : (stat_bit | dev_irq);
      if (mask_wr) mask_bit <= wdata[SRC_BIT];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: rdata = place_bit(stat_bit);
      SEL_MASK: rdata = place_bit(mask_bit);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_stat_req.sv
module irq_stat_req (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_bit,
  input  logic mask_bit,
  input  logic svc_req,
  output logic pend,
  output logic spur_evt,
  output logic irq_out,
  output logic spurious
);
  assign pend     = stat_bit & mask_bit;
  assign spur_evt = svc_req & ~pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_out  <= 1'b0;
      spurious <= 1'b0;
    end else begin
      irq_out  <= pend;
      spurious <= spur_evt;
    end
  end
endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SRC_BIT = 14,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h4C,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dev_irq,
  input  logic              svc_req,
  output logic              irq_out,
  output logic              spurious
);
  reg_sel_e sel_w;
  logic stat_w, mask_w, stat_clr_w, mask_wr_w, pend_w, spur_evt_w;

  irq_stat_dec #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)) u_dec (
    .addr(bus_addr), .sel(sel_w)
  );

  irq_stat_regs #(.DATA_W(DATA_W), .SRC_BIT(SRC_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel_w), .wr(bus_wr), .wdata(bus_wdata),
    .dev_irq(dev_irq), .stat_bit(stat_w), .mask_bit(mask_w),
    .stat_clr(stat_clr_w), .mask_wr(mask_wr_w), .rdata(bus_rdata)
  );

  irq_stat_req u_req (
    .clk(clk), .rst_n(rst_n), .stat_bit(stat_w), .mask_bit(mask_w),
    .svc_req(svc_req), .pend(pend_w), .spur_evt(spur_evt_w),
    .irq_out(irq_out), .spurious(spurious)
  );
endmodule

// File: rtl/irq_stat_chk.sv
module irq_stat_chk #(
  parameter int DATA_W  = 32,
  parameter int SRC_BIT = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dev_irq,
  input logic              svc_req,
  input logic [DATA_W-1:0] wdata,
  input logic              stat_bit,
  input logic              mask_bit,
  input logic              stat_clr,
  input logic              mask_wr,
  input logic              pend,
  input logic              irq_out,
  input logic              spurious
);
  // R2: a sampled request sets status unless a clear coincides
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dev_irq) && !$past(stat_clr)) |-> stat_bit);

  // R2: status is sticky without a clear
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(stat_bit) && !$past(stat_clr)) |-> stat_bit);

  // R3: a clearing write wins at its edge
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(stat_clr)) |-> !stat_bit);

  // R5: mask loads the written bit
  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mask_wr)) |-> (mask_bit == $past(wdata[SRC_BIT])));

  // R6: upstream line follows pending by one cycle
  p_irq_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_out == $past(pend)));

  // R7: spurious only after service with nothing pending
  p_spur_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spurious |-> ($past(rst_n) && $past(svc_req) && !$past(pend)));
endmodule

bind irq_stat_unit irq_stat_chk #(.DATA_W(DATA_W), .SRC_BIT(SRC_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .svc_req(svc_req),
  .wdata(bus_wdata), .stat_bit(stat_w), .mask_bit(mask_w),
  .stat_clr(stat_clr_w), .mask_wr(mask_wr_w), .pend(pend_w),
  .irq_out(irq_out), .spurious(spurious)
);

// File: tb/sim_irq_stat_unit.sv
`timescale 1ns/1ps
module sim_irq_stat_unit;
  localparam logic [7:0]  A_STAT = 8'h4C;
  localparam logic [7:0]  A_MASK = 8'h50;
  localparam logic [31:0] BIT14  = 32'h0000_4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        dev_irq = 1'b0;
  logic        svc_req = 1'b0;
  logic        irq_out, spurious;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_stat_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_irq(dev_irq),
    .svc_req(svc_req), .irq_out(irq_out), .spurious(spurious)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clean();
    dev_irq = 1'b0;
    bus_write(A_MASK, 32'h0);
    bus_write(A_STAT, BIT14);
    tick(1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(A_STAT, d); chk("R1 status", d, 32'h0);
    bus_read(A_MASK, d); chk("R1 mask", d, 32'h0);
    chk("R1 irq_out", {31'h0, irq_out}, 32'h0);
    chk("R1 spurious", {31'h0, spurious}, 32'h0);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    clean();
    dev_irq = 1'b1; tick(1); dev_irq = 1'b0;
    bus_read(A_STAT, d); chk("R2 set", d, BIT14);
    tick(3);
    bus_read(A_STAT, d); chk("R2 sticky", d, BIT14);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, d); chk("R3 zero write keeps", d, BIT14);
    bus_write(A_STAT, BIT14);
    bus_read(A_STAT, d); chk("R3 cleared", d, 32'h0);
  endtask

  task automatic t_w1c_held();
    logic [31:0] d;
    clean();
    dev_irq = 1'b1; tick(2);
    bus_write(A_STAT, BIT14);
    bus_read(A_STAT, d); chk("R4 clear wins at write edge", d, 32'h0);
    tick(1);
    bus_read(A_STAT, d); chk("R4 recaptured next edge", d, BIT14);
    dev_irq = 1'b0;
  endtask

  task automatic t_mask();
    logic [31:0] d;
    clean();
    bus_write(A_MASK, BIT14);
    bus_read(A_MASK, d); chk("R5 mask set", d, BIT14);
    bus_write(A_MASK, 32'h0);
    bus_read(A_MASK, d); chk("R5 mask clear", d, 32'h0);
  endtask

  task automatic t_irq_path();
    clean();
    bus_write(A_MASK, BIT14);
    dev_irq = 1'b1; tick(1); dev_irq = 1'b0;
    chk("R6 irq lags status", {31'h0, irq_out}, 32'h0);
    tick(1);
    chk("R6 irq asserted", {31'h0, irq_out}, 32'h1);
    bus_write(A_STAT, BIT14);
    chk("R6 irq one edge after clear", {31'h0, irq_out}, 32'h1);
    tick(1);
    chk("R6 irq dropped", {31'h0, irq_out}, 32'h0);
  endtask

  task automatic t_spurious();
    clean();
    bus_write(A_MASK, BIT14);
    svc_req = 1'b1; tick(1); svc_req = 1'b0;
    chk("R7 spurious pulse", {31'h0, spurious}, 32'h1);
    tick(1);
    chk("R7 pulse one cycle", {31'h0, spurious}, 32'h0);
    dev_irq = 1'b1; tick(1); dev_irq = 1'b0;
    svc_req = 1'b1; tick(1); svc_req = 1'b0;
    chk("R7 no pulse when pending", {31'h0, spurious}, 32'h0);
    bus_write(A_MASK, 32'h0);
    svc_req = 1'b1; tick(1); svc_req = 1'b0;
    chk("R7 masked source is not pending", {31'h0, spurious}, 32'h1);
  endtask

  task automatic t_other();
    logic [31:0] d;
    clean();
    bus_write(A_MASK, 32'hFFFF_FFFF);
    bus_read(A_MASK, d); chk("R8 mask other bits zero", d, BIT14);
    bus_write(A_MASK, ~BIT14);
    bus_read(A_MASK, d); chk("R8 mask other bits ignored", d, 32'h0);
    dev_irq = 1'b1; tick(1); dev_irq = 1'b0;
    bus_write(A_STAT, ~BIT14);
    bus_read(A_STAT, d); chk("R8 status other bits ignored", d, BIT14);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h4D, 32'hFFFF_FFFF);
    bus_read(8'h10, d); chk("R8 unmapped reads zero", d, 32'h0);
    bus_read(A_STAT, d); chk("R8 unmapped write keeps status", d, BIT14);
    bus_read(A_MASK, d); chk("R8 unmapped write keeps mask", d, 32'h0);
  endtask

  task automatic t_mask_ack();
    logic [31:0] d;
    clean();
    bus_write(A_MASK, BIT14);
    dev_irq = 1'b1; tick(2); dev_irq = 1'b0;
    chk("R9 irq before mask", {31'h0, irq_out}, 32'h1);
    bus_read(A_MASK, d);
    bus_write(A_MASK, d & ~BIT14);
    tick(1);
    chk("R9 irq off after mask", {31'h0, irq_out}, 32'h0);
    bus_read(A_STAT, d);
    bus_write(A_STAT, d | BIT14);
    bus_read(A_STAT, d); chk("R9 status acked", d, 32'h0);
    bus_read(A_MASK, d); chk("R9 mask off", d, 32'h0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_latch();
    t_w1c();
    t_w1c_held();
    t_mask();
    t_irq_path();
    t_spurious();
    t_other();
    t_mask_ack();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule